// File: doc/BRIEF.md
# Qualified Performance Event Counter

This block is a pair of programmable performance-monitoring counters. Each cycle, a small vector gives how many occurrences of an already-selected event class happened, along with an event identifier and the current privilege level of the processor. Each counter has its own control word. The control word holds these qualifiers:

- a threshold
- an invert flag
- an edge flag
- a kernel enable and a user enable
- an interrupt enable
- a run bit

The qualifiers decide whether a cycle's events count and by how much. Software can load each 40-bit count directly and read it at any time. When a count wraps, a sticky overflow flag is set, and it can raise an interrupt request.

Each counter runs a small state machine that remembers the qualified condition. The states are:

- `ST_OFF`: counting disabled, and the condition history is cleared.
- `ST_LOW`: enabled, and the condition was false in the last cycle.
- `ST_HIGH`: enabled, and the condition was true in the last cycle.

The transitions are:

- *activate* (`ST_OFF` to `ST_LOW` or `ST_HIGH`, chosen by the current condition).
- *rise* (`ST_LOW` to `ST_HIGH`; in edge mode this is the cycle that counts).
- *fall* (`ST_HIGH` to `ST_LOW`).
- *deactivate* (any state to `ST_OFF` when the counter stops being enabled).

The two counters share the event inputs and the privilege decode but never chain into each other. Each counter accepts only the event identifiers in its own allow mask.

Top module: `perf_qual_counter`

## Requirements
- R1: After reset both counts are 0, both overflow flags and both interrupt requests are 0, and both control words are 0, so nothing counts.
- R2: The control word is laid out as follows: bit 0 run, bit 1 kernel enable, bit 2 user enable, bit 3 edge, bit 4 invert, bit 5 interrupt enable, bits 8:6 threshold. A word written through `cfg_wr[i]` takes effect from the following cycle. With run clear, the count holds.
- R3: With a threshold of 0, the count grows by the full per-cycle event count, and the invert flag has no effect.
- R4: With a nonzero threshold and invert clear, the count grows by 1 in each cycle whose event count is at least the threshold.
- R5: With a nonzero threshold and invert set, the count grows by 1 in each cycle whose event count is below the threshold.
- R6: In edge mode, the count grows by 1 only in a cycle where the qualified condition is true and was false (or disabled) in the cycle before. With threshold 0, the condition is "event count nonzero".
- R7: Privilege level 0 counts only with the kernel enable set. Levels 1, 2 and 3 count only with the user enable set. In a cycle that is not enabled, the count holds and the edge history is cleared.
- R8: Counter 0 ignores event identifier 3, and counter 1 ignores event identifier 2; the count holds for an ignored identifier.
- R9: A write through `cnt_wr[i]` appears on the count one cycle later and takes priority over any increment in that cycle.
- R10: A count that passes 2^40-1 wraps to the remainder and sets that counter's overflow flag. The flag stays set until `ovf_clr[i]`; a new wrap in the clearing cycle wins.
- R11: The interrupt request of a counter is its overflow flag gated by its interrupt enable.
- R12: The counters are independent: a wrap or a write on one leaves the other's count and flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_count | input | 3 | Occurrences of the selected event in this cycle |
| evt_id | input | 2 | Identifier of the selected event class |
| priv_lvl | input | 2 | Current privilege level (0 = kernel) |
| cfg_wr | input | 2 | Per-counter control word write strobe |
| cfg_data | input | 9 | Control word to write |
| cnt_wr | input | 2 | Per-counter count write strobe |
| cnt_wdata | input | 40 | Count value to write |
| ovf_clr | input | 2 | Per-counter overflow flag clear |
| cnt_val0 | output | 40 | Count of counter 0 |
| cnt_val1 | output | 40 | Count of counter 1 |
| ovf_flag | output | 2 | Sticky overflow flags |
| irq | output | 2 | Overflow interrupt requests |

## Verification
The event count is driven through the following sequences:

- **Mixed values with threshold 0.** This separates summing from one-per-cycle counting, and it shows that invert is ignored.
- **Values below, at and above a threshold, with invert clear and set.** This exposes an off-by-one in the comparison and a missing inversion.
- **A condition that stays true for several cycles.** This shows whether edge mode counts transitions or cycles.
- **Privilege and identifier sweeps.** These check the gating. One sweep interrupts a held condition with a disabled cycle, to show that the edge history is cleared.
- **A near-full count.** This checks the wrap value, the sticky flag, the clear, the interrupt gating, and that the other counter stays untouched.

// File: rtl/pqc_pkg.sv
package pqc_pkg;
    // control word bit positions
    localparam int unsigned CFG_RUN  = 0;
    localparam int unsigned CFG_KERN = 1;
    localparam int unsigned CFG_USER = 2;
    localparam int unsigned CFG_EDGE = 3;
    localparam int unsigned CFG_INV  = 4;
    localparam int unsigned CFG_IRQ  = 5;
    localparam int unsigned CFG_TH   = 6;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } cnt_st_e;
endpackage

// File: rtl/pqc_qualify.sv
module pqc_qualify #(
    parameter int unsigned EW = 3
) (
    input  logic [EW-1:0] evt,
    input  logic [EW-1:0] thresh,
    input  logic          inv,
    output logic          cond,
    output logic [EW-1:0] weight
);
    logic th_zero;
    logic ge;

    assign th_zero = (thresh == '0);
    assign ge      = (evt >= thresh);

    always_comb begin
        if (th_zero) begin
            cond   = (evt != '0);
            weight = evt;
        end else begin
            cond   = inv ? !ge : ge;
            weight = {{(EW-1){1'b0}}, cond};
        end
    end
endmodule

// File: rtl/pqc_counter.sv
module pqc_counter
    import pqc_pkg::*;
#(
    parameter int unsigned CW   = 40,
    parameter int unsigned EW   = 3,
    parameter int unsigned CFGW = EW + 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CFGW-1:0] cfg,
    input  logic            is_kernel,
    input  logic            allowed,
    input  logic [EW-1:0]   evt,
    input  logic            wr,
    input  logic [CW-1:0]   wdata,
    input  logic            clr,
    output logic [CW-1:0]   cnt_q,
    output logic            ovf_q,
    output logic            irq
);
    logic          cond;
    logic [EW-1:0] weight;
    logic          priv_ok;
    logic          active;
    logic [EW-1:0] inc;
    logic [CW:0]   sum;
    cnt_st_e       st_q, st_d;

    pqc_qualify #(.EW(EW)) qual_i (
        .evt    (evt),
        .thresh (cfg[CFG_TH +: EW]),
        .inv    (cfg[CFG_INV]),
        .cond   (cond),
        .weight (weight)
    );

    assign priv_ok = is_kernel ? cfg[CFG_KERN] : cfg[CFG_USER];
    assign active  = cfg[CFG_RUN] && priv_ok && allowed;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_d;
    end

    // next state and increment
    always_comb begin
        st_d = st_q;
        inc  = '0;
        unique case (st_q)
            ST_OFF, ST_LOW: begin
                if (!active) st_d = ST_OFF;
                else begin
                    st_d = cond ? ST_HIGH : ST_LOW;
                    if (cfg[CFG_EDGE]) inc = {{(EW-1){1'b0}}, cond};
                    else               inc = weight;
                end
            end
            ST_HIGH: begin
                if (!active) st_d = ST_OFF;
                else begin
                    st_d = cond ? ST_HIGH : ST_LOW;
                    if (!cfg[CFG_EDGE]) inc = weight;
                end
            end
            default: st_d = ST_OFF;
        endcase
    end

    assign sum = {1'b0, cnt_q} + {{(CW+1-EW){1'b0}}, inc};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            cnt_q <= wr ? wdata : sum[CW-1:0];
            if (sum[CW] && !wr) ovf_q <= 1'b1;
            else if (clr)       ovf_q <= 1'b0;
        end
    end

    assign irq = ovf_q && cfg[CFG_IRQ];
endmodule

// File: rtl/perf_qual_counter.sv
module perf_qual_counter #(
    parameter int unsigned CW     = 40,
    parameter int unsigned EW     = 3,
    parameter int unsigned IDW    = 2,
    parameter logic [3:0]  ALLOW0 = 4'b0111,
    parameter logic [3:0]  ALLOW1 = 4'b1011
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [EW-1:0]   evt_count,
    input  logic [IDW-1:0]  evt_id,
    input  logic [1:0]      priv_lvl,
    input  logic [1:0]      cfg_wr,
    input  logic [EW+5:0]   cfg_data,
    input  logic [1:0]      cnt_wr,
    input  logic [CW-1:0]   cnt_wdata,
    input  logic [1:0]      ovf_clr,
    output logic [CW-1:0]   cnt_val0,
    output logic [CW-1:0]   cnt_val1,
    output logic [1:0]      ovf_flag,
    output logic [1:0]      irq
);
    localparam int unsigned NCNT = 2;
    localparam int unsigned CFGW = EW + 6;

    logic                       is_kernel;
    logic [NCNT-1:0][CFGW-1:0]  cfg_q;
    logic [NCNT-1:0][CW-1:0]    cnt_w;
    logic [NCNT-1:0]            allow_w;

    assign is_kernel = (priv_lvl == 2'd0);

    for (genvar i = 0; i < NCNT; i++) begin : g_cnt
        if (i == 0) begin : g_m0
            assign allow_w[i] = ALLOW0[evt_id];
        end else begin : g_m1
            assign allow_w[i] = ALLOW1[evt_id];
        end

        always_ff @(posedge clk) begin
            if (!rst_n)         cfg_q[i] <= '0;
            else if (cfg_wr[i]) cfg_q[i] <= cfg_data;
        end

        pqc_counter #(.CW(CW), .EW(EW), .CFGW(CFGW)) cnt_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg       (cfg_q[i]),
            .is_kernel (is_kernel),
            .allowed   (allow_w[i]),
            .evt       (evt_count),
            .wr        (cnt_wr[i]),
            .wdata     (cnt_wdata),
            .clr       (ovf_clr[i]),
            .cnt_q     (cnt_w[i]),
            .ovf_q     (ovf_flag[i]),
            .irq       (irq[i])
        );
    end

    assign cnt_val0 = cnt_w[0];
    assign cnt_val1 = cnt_w[1];
endmodule

// File: rtl/pqc_checker.sv
module pqc_checker #(
    parameter int unsigned CW   = 40,
    parameter int unsigned EW   = 3,
    parameter int unsigned CFGW = EW + 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      priv_lvl,
    input logic [1:0]      cnt_wr,
    input logic [CW-1:0]   cnt_wdata,
    input logic [CW-1:0]   cnt_val0,
    input logic [CW-1:0]   cnt_val1,
    input logic [1:0]      ovf_flag,
    input logic [CFGW-1:0] cfg0
);
    localparam logic [CW-1:0] MAX_STEP = CW'((1 << EW) - 1);

    AST_WRITE_WINS0: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cnt_wr[0]) |-> cnt_val0 == $past(cnt_wdata)); // R9
    AST_WRITE_WINS1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cnt_wr[1]) |-> cnt_val1 == $past(cnt_wdata)); // R9
    AST_RUN_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cfg0[0]) && !$past(cnt_wr[0])) |-> cnt_val0 == $past(cnt_val0)); // R2
    AST_PRIV_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cnt_wr[0]) &&
         (($past(priv_lvl) == 2'd0) ? !$past(cfg0[1]) : !$past(cfg0[2])))
        |-> cnt_val0 == $past(cnt_val0)); // R7
    AST_WRAP_SETS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cnt_wr[0]) && (cnt_val0 < $past(cnt_val0))) |-> ovf_flag[0]); // R10
    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cnt_wr[0]) |-> (cnt_val0 - $past(cnt_val0)) <= MAX_STEP); // R3
endmodule

bind perf_qual_counter pqc_checker #(.CW(CW), .EW(EW), .CFGW(EW + 6)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .priv_lvl  (priv_lvl),
    .cnt_wr    (cnt_wr),
    .cnt_wdata (cnt_wdata),
    .cnt_val0  (cnt_val0),
    .cnt_val1  (cnt_val1),
    .ovf_flag  (ovf_flag),
    .cfg0      (cfg_q[0])
);

// File: tb/perf_qual_counter_tb_top.sv
module perf_qual_counter_tb_top;
    localparam int CW = 40;
    localparam logic [8:0] RUN = 9'd1, KERN = 9'd2, USER = 9'd4,
                           EDGE = 9'd8, INV = 9'd16, IRQE = 9'd32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    evt_count = '0;
    logic [1:0]    evt_id = '0;
    logic [1:0]    priv_lvl = '0;
    logic [1:0]    cfg_wr = '0;
    logic [8:0]    cfg_data = '0;
    logic [1:0]    cnt_wr = '0;
    logic [CW-1:0] cnt_wdata = '0;
    logic [1:0]    ovf_clr = '0;
    logic [CW-1:0] cnt_val0, cnt_val1;
    logic [1:0]    ovf_flag, irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    perf_qual_counter dut_i (
        .clk(clk), .rst_n(rst_n), .evt_count(evt_count), .evt_id(evt_id),
        .priv_lvl(priv_lvl), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .ovf_clr(ovf_clr),
        .cnt_val0(cnt_val0), .cnt_val1(cnt_val1), .ovf_flag(ovf_flag), .irq(irq)
    );

    task automatic check(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        cfg_wr = '0; cnt_wr = '0; ovf_clr = '0;
    endtask

    task automatic setcfg(input int i, input logic [8:0] d);
        evt_count = '0; cfg_data = d; cfg_wr[i] = 1'b1; tick();
    endtask

    task automatic setcnt(input int i, input logic [CW-1:0] v);
        evt_count = '0; cnt_wdata = v; cnt_wr[i] = 1'b1; tick();
    endtask

    task automatic ev(input logic [2:0] e);
        evt_count = e; tick();
    endtask

    task automatic t_reset();
        check("R1 cnt0", cnt_val0, 0);
        check("R1 cnt1", cnt_val1, 0);
        check("R1 ovf", {38'd0, ovf_flag}, 0);
        check("R1 irq", {38'd0, irq}, 0);
        ev(5);
        check("R1 idle after reset", cnt_val0, 0);
    endtask

    task automatic t_thresh0();
        setcfg(0, RUN | KERN | USER | INV);
        setcnt(0, 0);
        ev(3); ev(5); ev(0); ev(7);
        check("R3 full sum, invert ignored", cnt_val0, 15);
        setcfg(0, KERN | USER);
        ev(7); ev(7);
        check("R2 run clear holds", cnt_val0, 15);
    endtask

    task automatic t_thresh();
        setcfg(0, RUN | KERN | USER | (9'd4 << 6));
        setcnt(0, 0);
        ev(3); ev(4); ev(7); ev(5); ev(0);
        check("R4 at or above threshold", cnt_val0, 3);
    endtask

    task automatic t_inv();
        setcfg(0, RUN | KERN | USER | INV | (9'd4 << 6));
        setcnt(0, 0);
        ev(3); ev(4); ev(7); ev(0); ev(1);
        check("R5 below threshold", cnt_val0, 3);
    endtask

    task automatic t_edge();
        setcfg(0, RUN | KERN | USER | EDGE | (9'd2 << 6));
        setcnt(0, 0);
        ev(2); ev(3); ev(0); ev(5); ev(5); ev(1); ev(4);
        check("R6 edge with threshold", cnt_val0, 3);
        setcfg(0, RUN | KERN | USER | EDGE);
        setcnt(0, 0);
        ev(1); ev(1); ev(0); ev(6);
        check("R6 edge with threshold 0", cnt_val0, 2);
    endtask

    task automatic t_priv();
        setcfg(0, RUN | KERN);
        setcnt(0, 0);
        priv_lvl = 0; ev(2);
        priv_lvl = 3; ev(2);
        check("R7 kernel only", cnt_val0, 2);
        setcfg(0, RUN | USER);
        setcnt(0, 0);
        priv_lvl = 2; ev(1);
        priv_lvl = 0; ev(1);
        check("R7 user only", cnt_val0, 1);
        setcfg(0, RUN | KERN | EDGE);
        setcnt(0, 0);
        priv_lvl = 0; ev(1);
        priv_lvl = 1; ev(1);
        priv_lvl = 0; ev(1);
        check("R7 edge history cleared", cnt_val0, 2);
        priv_lvl = 0;
    endtask

    task automatic t_mask();
        setcfg(0, RUN | KERN | USER);
        setcfg(1, RUN | KERN | USER);
        setcnt(0, 0);
        setcnt(1, 0);
        evt_id = 3; ev(2);
        evt_id = 2; ev(1);
        evt_id = 0; evt_count = 0;
        check("R8 counter0 mask", cnt_val0, 1);
        check("R8 counter1 mask", cnt_val1, 2);
    endtask

    task automatic t_write();
        setcfg(0, RUN | KERN | USER);
        evt_count = 7; cnt_wdata = 100; cnt_wr[0] = 1'b1; tick();
        check("R9 write wins", cnt_val0, 100);
        ev(7);
        check("R9 count after write", cnt_val0, 107);
    endtask

    task automatic t_wrap();
        setcfg(0, KERN | USER);
        setcnt(0, 0);
        setcfg(1, RUN | KERN | USER | IRQE);
        setcnt(1, {CW{1'b1}} - 1);
        ev(3);
        check("R10 wrap value", cnt_val1, 1);
        check("R10 ovf set", {39'd0, ovf_flag[1]}, 1);
        check("R11 irq on", {39'd0, irq[1]}, 1);
        check("R12 other ovf", {39'd0, ovf_flag[0]}, 0);
        check("R12 other count", cnt_val0, 0);
        ev(0);
        check("R10 ovf sticky", {39'd0, ovf_flag[1]}, 1);
        ovf_clr[1] = 1'b1; ev(0);
        check("R10 ovf cleared", {39'd0, ovf_flag[1]}, 0);
        check("R11 irq off", {39'd0, irq[1]}, 0);
        setcfg(1, RUN | KERN | USER);
        setcnt(1, {CW{1'b1}});
        ev(1);
        check("R11 ovf without irq enable", {39'd0, ovf_flag[1]}, 1);
        check("R11 irq masked", {39'd0, irq[1]}, 0);
        setcnt(1, {CW{1'b1}});
        evt_count = 2; ovf_clr[1] = 1'b1; tick();
        check("R10 wrap beats clear", {39'd0, ovf_flag[1]}, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_thresh0();
        t_thresh();
        t_inv();
        t_edge();
        t_priv();
        t_mask();
        t_write();
        t_wrap();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule